// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and calendar date as packed two-digit BCD fields. Each BCD field holds the tens digit in bits [7:4] and the units digit in bits [3:0]. The fields are seconds, minutes, 24-hour hours, day of week, day of month, month and a two-digit year. A prescaler outside the block produces a one-cycle tick once per second, and each tick advances the chain by one second. Carries ripple from seconds up through the year within the same clock cycle. Month lengths follow the calendar: February gets 29 days in years divisible by four and 28 otherwise, with no century exception.

A surrounding register bank can replace all seven fields in one cycle with a load strobe, and counting then resumes from the loaded values. A load beats a tick that arrives in the same cycle. A stop input freezes the count without blocking loads. All fields are driven continuously on outputs so that a bank can snapshot them.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00.
- R2: Fields are packed BCD (tens in bits [7:4], units in [3:0]); each accepted tick adds one second, seconds and minutes run 00-59, and a wrap from 59 to 00 carries into the next field.
- R3: Hours run 00-23; the carry from 23:59:59 sets the time to 00:00:00 and advances the date.
- R4: Day of week runs 01-07 and advances at every midnight, rolling 07 to 01 independently of the date.
- R5: Months 04, 06, 09 and 11 end after date 30 and all others except 02 after date 31; the day after the last date is 01 of the next month, and month 12 rolls to 01 with a carry into the year.
- R6: February ends after date 29 when the two-digit year is a multiple of four (including 00) and after date 28 otherwise.
- R7: Year 99 rolls to 00.
- R8: A load strobe replaces all seven fields at the next clock edge, and later ticks count on from the loaded values.
- R9: While stop is high, ticks leave every field unchanged.
- R10: When load and tick are both high in one cycle, the fields take the loaded values with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-second advance strobe |
| stop_i | input | 1 | Freeze counting while high |
| load_i | input | 1 | Parallel load strobe for all fields |
| ld_sec_i | input | 8 | Seconds value to load (BCD) |
| ld_min_i | input | 8 | Minutes value to load (BCD) |
| ld_hour_i | input | 8 | Hours value to load (BCD) |
| ld_dow_i | input | 8 | Day-of-week value to load (BCD) |
| ld_date_i | input | 8 | Date value to load (BCD) |
| ld_mon_i | input | 8 | Month value to load (BCD) |
| ld_year_i | input | 8 | Year value to load (BCD) |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours |
| dow_o | output | 8 | Current day of week |
| date_o | output | 8 | Current date |
| mon_o | output | 8 | Current month |
| year_o | output | 8 | Current year |

## Verification
The range properties assume that every load carries a legal calendar value: valid BCD digits, fields within their ranges, and a date that exists in the loaded month and year. The block itself does not clamp illegal loads, so a load that breaks this assumption is outside what the properties cover. The stimulus only loads values from a table of legal dates and times, with the load strobe used only after the internal reset has been released. The properties also take `load_i` as the only source of field changes other than an accepted tick, so the bench keeps `tick_i` low except when it means to advance.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BCD_W = 8;
  typedef logic [BCD_W-1:0] bcd2_t;

  // add one to a two-digit packed BCD value
  function automatic bcd2_t bcd_inc(input bcd2_t v);
    bcd2_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // 10*T + U is a multiple of 4 exactly when (2*T + U) mod 4 == 0
  function automatic logic bcd_leap(input bcd2_t yr);
    logic [1:0] m;
    m = yr[1:0] + {yr[4], 1'b0};
    return (m == 2'd0);
  endfunction
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  bcd2_t mon_i,
  input  bcd2_t year_i,
  output bcd2_t last_o
);
  always_comb begin
    unique case (mon_i)
      8'h02:                      last_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter bcd2_t FIRST = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  ld_i,
  input  bcd2_t ld_val_i,
  input  bcd2_t last_i,
  output bcd2_t q_o,
  output logic  wrap_o
);
  bcd2_t q_q, q_d;
  logic  at_end;

  assign at_end = (q_q >= last_i);

  always_comb begin
    q_d = q_q;
    if (ld_i)      q_d = ld_val_i;
    else if (en_i) q_d = at_end ? FIRST : bcd_inc(q_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q_q <= FIRST;
    else if (ld_i || en_i) q_q <= q_d;
  end

  assign q_o    = q_q;
  assign wrap_o = en_i & at_end;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       stop_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  // chain order: seconds, minutes, hours, date, month, year
  localparam int NCH = 6;
  localparam int IX_DATE = 3;
  localparam bcd2_t FIRST_V [NCH] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
  localparam bcd2_t LAST_V  [NCH] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99};

  logic  rst_sync_n;
  logic  cnt_en;
  logic  [NCH-1:0] en_c, wrap_c;
  bcd2_t ld_c   [NCH];
  bcd2_t q_c    [NCH];
  bcd2_t last_c [NCH];
  bcd2_t date_last;
  logic  dow_wrap;

  cal_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign cnt_en = tick_i & ~stop_i & ~load_i;

  assign ld_c[0] = ld_sec_i;
  assign ld_c[1] = ld_min_i;
  assign ld_c[2] = ld_hour_i;
  assign ld_c[3] = ld_date_i;
  assign ld_c[4] = ld_mon_i;
  assign ld_c[5] = ld_year_i;

  cal_month_len u_mlen (.mon_i(q_c[4]), .year_i(q_c[5]), .last_o(date_last));

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    if (i == 0) begin : g_en0
      assign en_c[i] = cnt_en;
    end else begin : g_enn
      assign en_c[i] = wrap_c[i-1];
    end
    if (i == IX_DATE) begin : g_dyn
      assign last_c[i] = date_last;
    end else begin : g_fix
      assign last_c[i] = LAST_V[i];
    end
    cal_bcd_field #(.FIRST(FIRST_V[i])) u_fld (
      .clk(clk), .rst_n(rst_sync_n), .en_i(en_c[i]), .ld_i(load_i),
      .ld_val_i(ld_c[i]), .last_i(last_c[i]), .q_o(q_c[i]), .wrap_o(wrap_c[i]));
  end

  // day of week steps on the hour wrap, apart from the date
  cal_bcd_field #(.FIRST(8'h01)) u_dow (
    .clk(clk), .rst_n(rst_sync_n), .en_i(wrap_c[2]), .ld_i(load_i),
    .ld_val_i(ld_dow_i), .last_i(8'h07), .q_o(dow_o), .wrap_o(dow_wrap));

  assign sec_o  = q_c[0];
  assign min_o  = q_c[1];
  assign hour_o = q_c[2];
  assign date_o = q_c[3];
  assign mon_o  = q_c[4];
  assign year_o = q_c[5];
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       stop_i,
  input logic       load_i,
  input logic [7:0] ld_sec_i,
  input logic [7:0] ld_min_i,
  input logic [7:0] ld_hour_i,
  input logic [7:0] ld_dow_i,
  input logic [7:0] ld_date_i,
  input logic [7:0] ld_mon_i,
  input logic [7:0] ld_year_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o
);
  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[3:0] <= 4'd9 && sec_o <= 8'h59);
  p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hour_o[3:0] <= 4'd9 && hour_o <= 8'h23);
  p_dow_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dow_o >= 8'h01 && dow_o <= 8'h07);
  p_month_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mon_o >= 8'h01 && mon_o <= 8'h12);
  p_feb_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mon_o == 8'h02 |-> date_o <= 8'h29);
  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && sec_o != 8'h59 |=> $stable(min_o));
  p_day_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !(hour_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59)
    |=> $stable(dow_o) && $stable(date_o));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
               hour_o == $past(ld_hour_i) && dow_o == $past(ld_dow_i) &&
               date_o == $past(ld_date_i) && mon_o == $past(ld_mon_i) &&
               year_o == $past(ld_year_i));
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !load_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                          $stable(dow_o) && $stable(date_o) && $stable(mon_o) &&
                          $stable(year_o));
  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !stop_i && !load_i |=> !$stable(sec_o));
endmodule

bind bcd_calendar cal_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .stop_i(stop_i), .load_i(load_i),
  .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_dow_i(ld_dow_i),
  .ld_date_i(ld_date_i), .ld_mon_i(ld_mon_i), .ld_year_i(ld_year_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
  .date_o(date_o), .mon_o(mon_o), .year_o(year_o));

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;
  // each entry: {start, expected after one tick}; field order year,mon,date,dow,hour,min,sec
  localparam logic [111:0] VEC [NV] = '{
    {56'h23051403102030, 56'h23051403102031},
    {56'h23051403102059, 56'h23051403102100},
    {56'h23051403105959, 56'h23051403110000},
    {56'h19090904090909, 56'h19090904090910},
    {56'h23051403235959, 56'h23051504000000},
    {56'h23051407235959, 56'h23051501000000},
    {56'h23043002235959, 56'h23050103000000},
    {56'h23053002235959, 56'h23053103000000},
    {56'h23113001235959, 56'h23120102000000},
    {56'h23022802235959, 56'h23030103000000},
    {56'h24022802235959, 56'h24022903000000},
    {56'h24022903235959, 56'h24030104000000},
    {56'h12022802235959, 56'h12022903000000},
    {56'h10022802235959, 56'h10030103000000},
    {56'h00022801235959, 56'h00022902000000},
    {56'h23123106235959, 56'h24010107000000},
    {56'h99123105235959, 56'h00010106000000}
  };

  logic clk, rst_n, tick_i, stop_i, load_i;
  logic [7:0] ld_sec_i, ld_min_i, ld_hour_i, ld_dow_i, ld_date_i, ld_mon_i, ld_year_i;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;
  int checks, errors;
  string vtag [NV];

  bcd_calendar dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [55:0] now_fields();
    return {year_o, mon_o, date_o, dow_o, hour_o, min_o, sec_o};
  endfunction

  task automatic check(input string tag, input logic [55:0] exp);
    checks++;
    if (now_fields() !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, now_fields(), exp);
    end
  endtask

  task automatic drive_load(input logic [55:0] v);
    {ld_year_i, ld_mon_i, ld_date_i, ld_dow_i, ld_hour_i, ld_min_i, ld_sec_i} = v;
    load_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    vtag = '{"R2", "R2", "R2", "R2", "R3", "R4", "R5", "R5", "R5",
             "R6", "R6", "R6", "R6", "R6", "R6", "R5", "R7"};
    rst_n = 1'b0; tick_i = 1'b0; stop_i = 1'b0; load_i = 1'b0;
    {ld_year_i, ld_mon_i, ld_date_i, ld_dow_i, ld_hour_i, ld_min_i, ld_sec_i} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", 56'h00010101000000);

    for (int i = 0; i < NV; i++) begin
      drive_load(VEC[i][111:56]);
      @(negedge clk);
      load_i = 1'b0;
      check("R8", VEC[i][111:56]);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      check(vtag[i], VEC[i][55:0]);
    end

    // R2: sixty back-to-back ticks advance one minute
    drive_load(56'h23051403102000);
    @(negedge clk);
    load_i = 1'b0;
    tick_i = 1'b1;
    repeat (60) @(negedge clk);
    tick_i = 1'b0;
    check("R2", 56'h23051403102100);

    // R9: stop freezes all fields despite ticks
    drive_load(56'h23051403235959);
    @(negedge clk);
    load_i = 1'b0;
    stop_i = 1'b1; tick_i = 1'b1;
    repeat (5) @(negedge clk);
    tick_i = 1'b0;
    check("R9", 56'h23051403235959);
    stop_i = 1'b0;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check("R9", 56'h23051504000000);

    // R10: load wins over a simultaneous tick
    drive_load(56'h99123105235959);
    tick_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; tick_i = 1'b0;
    check("R10", 56'h99123105235959);

    // R8: counting continues from loaded value, several ticks
    tick_i = 1'b1;
    repeat (3) @(negedge clk);
    tick_i = 1'b0;
    check("R8", 56'h00010106000002);

    // R1: asynchronous reset mid-run returns to reset values
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 56'h00010101000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 56'h00010101000000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule